// File: doc/BRIEF.md
# Pipelined Karatsuba GF(2^m) Multiplier

This block multiplies two elements of a binary extension field GF(2^m) in polynomial basis. Addition in the field is bitwise XOR and every partial product is carry-less. The top level splits the operands into a low half and a high half. It forms three half-size products: low times low, high times high, and the XOR of the halves times the XOR of the halves. Each half-size product is built the same way, recursively, until a small schoolbook leaf is reached. Widths that do not split evenly are zero-extended at each level.

The combined double-width product is reduced modulo the field polynomial inside the same pipeline. Two folding passes map every coefficient at position m or above back into the field, so the output is already a field element. The pipeline has five register stages and takes a new operand pair on every clock. The field size and the low terms of the field polynomial are set by parameters. The default is m = 233 with f(x) = x^233 + x^74 + 1. A valid flag moves with the data through all five stages.

Top module: `gf_kmul_pipe`

## Requirements
- R1: For any pair of operands, `out_prod` equals a·b mod f(x) as an m-bit field element. The default field has m = 233, and bit k of each bus is the coefficient of x^k.
- R2: An operand pair captured by a rising edge with `in_valid` high gives `out_valid` high and its product after the fourth following rising edge. That is five register stages, counting the capture edge.
- R3: A valid pair may be presented on every cycle with no stall. Results come out in issue order. A cycle with `in_valid` low produces a cycle with `out_valid` low five stages later.
- R4: `rst_n` low clears every valid bit at once. `out_valid` stays low until a freshly captured pair has passed all five stages.
- R5: If either operand is zero, the product is zero.
- R6: If one operand is the constant 1 (only bit 0 set), the product equals the other operand.
- R7: On a cycle when no valid result enters the last stage, `out_prod` keeps its previous value.
- R8: Operands whose product reaches the highest degrees are reduced fully through both folds. Examples are the all-ones element and x^(m-1) times itself.
- R9: The zero bits added to the upper half when a width is odd never change the result. This also holds for operands whose only set bit is m-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears the valid bits only |
| in_valid | input | 1 | Marks `in_a`/`in_b` as an operand pair to capture |
| in_a | input | M | First operand, polynomial basis |
| in_b | input | M | Second operand, polynomial basis |
| out_valid | output | 1 | Marks `out_prod` as a fresh result |
| out_prod | output | M | Reduced product |

## Verification
A pair captured at one rising edge appears at the outputs after the fourth edge that follows it. The bench drives inputs and reads outputs on falling edges. At loop step j it drives pair j, and it first compares the outputs against pair j-5, so every comparison lands exactly on the cycle the result is due. Bubble slots are checked five steps later for a low `out_valid` and an unchanged product. After a mid-stream reset, `out_valid` is checked low at once and for the following cycles, and then one fresh pair is timed from its capture edge.

// File: rtl/gf_pkg.sv
package gf_pkg;

  // Index of the highest set bit; 0 when the vector is empty.
  function automatic int msb_pos(input logic [1023:0] v);
    int pos;
    pos = 0;
    for (int i = 0; i < 1024; i++) begin
      if (v[i]) pos = i;
    end
    return pos;
  endfunction

  // Width of the lower half when a W-bit operand is split.
  function automatic int half_w(input int w);
    return (w + 1) / 2;
  endfunction

endpackage

// File: rtl/gf_kara_core.sv
// Recursive carry-less Karatsuba multiplier, purely combinational.
// The upper half is zero-extended to the lower half width at each level.
module gf_kara_core #(
  parameter int W    = 16,
  parameter int LEAF = 16
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-2:0] p
);

  generate
    if (W <= LEAF) begin : g_leaf
      logic [2*W-2:0] acc;
      always_comb begin
        acc = '0;
        for (int i = 0; i < W; i++) begin
          if (a[i]) acc = acc ^ ((2*W-1)'(b) << i);
        end
      end
      assign p = acc;
    end else begin : g_split
      localparam int H  = gf_pkg::half_w(W);
      localparam int PW = 2*H - 1;

      logic [H-1:0]  a_lo, a_hi, b_lo, b_hi, a_x, b_x;
      logic [PW-1:0] p_ll, p_hh, p_xx, p_mid;

      assign a_lo = a[H-1:0];
      assign b_lo = b[H-1:0];
      assign a_hi = H'(a[W-1:H]);
      assign b_hi = H'(b[W-1:H]);
      assign a_x  = a_lo ^ a_hi;
      assign b_x  = b_lo ^ b_hi;

      gf_kara_core #(.W(H), .LEAF(LEAF)) u_ll (.a(a_lo), .b(b_lo), .p(p_ll));
      gf_kara_core #(.W(H), .LEAF(LEAF)) u_hh (.a(a_hi), .b(b_hi), .p(p_hh));
      gf_kara_core #(.W(H), .LEAF(LEAF)) u_xx (.a(a_x),  .b(b_x),  .p(p_xx));

      assign p_mid = p_xx ^ p_ll ^ p_hh;
      assign p = (2*W-1)'(p_ll)
               ^ ((2*W-1)'(p_mid) << H)
               ^ ((2*W-1)'(p_hh) << (2*H));
    end
  endgenerate

endmodule

// File: rtl/gf_fold.sv
// One reduction pass: every coefficient at x^(M+k) is replaced by x^k * POLY_LOW.
module gf_fold #(
  parameter int             M        = 233,
  parameter int             IN_W     = 465,
  parameter int             OUT_W    = 306,
  parameter logic [M-1:0]   POLY_LOW = (M'(1) << 74) | M'(1)
) (
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] dout
);

  localparam int HI_W = IN_W - M;

  logic [OUT_W-1:0] acc;

  always_comb begin
    acc = OUT_W'(din[M-1:0]);
    for (int k = 0; k < HI_W; k++) begin
      if (din[M+k]) acc = acc ^ (OUT_W'(POLY_LOW) << k);
    end
  end

  assign dout = acc;

endmodule

// File: rtl/gf_kmul_pipe.sv
// Five-stage GF(2^m) multiplier:
//   S1 operand capture, S2 three half-size products, S3 recombination,
//   S4 first reduction fold, S5 second fold (output).
module gf_kmul_pipe #(
  parameter int           M        = 233,
  parameter logic [M-1:0] POLY_LOW = (M'(1) << 74) | M'(1),
  parameter int           LEAF     = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [M-1:0] in_a,
  input  logic [M-1:0] in_b,
  output logic         out_valid,
  output logic [M-1:0] out_prod
);

  localparam int H  = gf_pkg::half_w(M);
  localparam int PW = 2*H - 1;
  localparam int FW = 2*M - 1;
  localparam int CW = 4*H - 1;
  localparam int T  = gf_pkg::msb_pos(1024'(POLY_LOW));
  localparam int RW = M - 1 + T;

  // ---------------- valid chain ----------------
  logic s1_v, s2_v, s3_v, s4_v, s5_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v <= 1'b0;
      s2_v <= 1'b0;
      s3_v <= 1'b0;
      s4_v <= 1'b0;
      s5_v <= 1'b0;
    end else begin
      s1_v <= in_valid;
      s2_v <= s1_v;
      s3_v <= s2_v;
      s4_v <= s3_v;
      s5_v <= s4_v;
    end
  end

  // ---------------- S1: operand capture ----------------
  logic [M-1:0] s1_a, s1_b;

  always_ff @(posedge clk) begin
    if (in_valid) begin
      s1_a <= in_a;
      s1_b <= in_b;
    end
  end

  // ---------------- S2: top-level Karatsuba products ----------------
  logic [H-1:0]  a_lo, a_hi, b_lo, b_hi, a_x, b_x;
  logic [PW-1:0] ll_d, hh_d, xx_d;
  logic [PW-1:0] s2_ll, s2_hh, s2_xx;

  always_comb begin
    a_lo = s1_a[H-1:0];
    b_lo = s1_b[H-1:0];
    a_hi = H'(s1_a[M-1:H]);
    b_hi = H'(s1_b[M-1:H]);
    a_x  = a_lo ^ a_hi;
    b_x  = b_lo ^ b_hi;
  end

  gf_kara_core #(.W(H), .LEAF(LEAF)) u_pp_ll (.a(a_lo), .b(b_lo), .p(ll_d));
  gf_kara_core #(.W(H), .LEAF(LEAF)) u_pp_hh (.a(a_hi), .b(b_hi), .p(hh_d));
  gf_kara_core #(.W(H), .LEAF(LEAF)) u_pp_xx (.a(a_x),  .b(b_x),  .p(xx_d));

  always_ff @(posedge clk) begin
    if (s1_v) begin
      s2_ll <= ll_d;
      s2_hh <= hh_d;
      s2_xx <= xx_d;
    end
  end

  // ---------------- S3: recombination ----------------
  logic [CW-1:0] comb_wide;
  logic [FW-1:0] full_d, s3_full;

  always_comb begin
    comb_wide = CW'(s2_ll)
              ^ (CW'(s2_xx ^ s2_ll ^ s2_hh) << H)
              ^ (CW'(s2_hh) << (2*H));
    full_d    = comb_wide[FW-1:0];
  end

  always_ff @(posedge clk) begin
    if (s2_v) s3_full <= full_d;
  end

  // ---------------- S4: first fold ----------------
  logic [RW-1:0] part_d, s4_part;

  gf_fold #(.M(M), .IN_W(FW), .OUT_W(RW), .POLY_LOW(POLY_LOW)) u_fold_a (
    .din(s3_full), .dout(part_d)
  );

  always_ff @(posedge clk) begin
    if (s3_v) s4_part <= part_d;
  end

  // ---------------- S5: second fold ----------------
  logic [M-1:0] prod_d, s5_prod;

  gf_fold #(.M(M), .IN_W(RW), .OUT_W(M), .POLY_LOW(POLY_LOW)) u_fold_b (
    .din(s4_part), .dout(prod_d)
  );

  always_ff @(posedge clk) begin
    if (s4_v) s5_prod <= prod_d;
  end

  assign out_valid = s5_v;
  assign out_prod  = s5_prod;

  // ---------------- checks ----------------
  logic [2:0] since_rst;
  logic       filled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rst <= 3'd0;
      filled    <= 1'b0;
    end else begin
      if (since_rst != 3'd5) since_rst <= since_rst + 3'd1;
      if (s4_v) filled <= 1'b1;
    end
  end

  // R4
  no_early_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst < 3'd5) |-> !out_valid);

  // R2
  latency_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 3'd5) |-> (out_valid == $past(in_valid, 5)));

  // R5
  zero_prod_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_a == '0 || in_b == '0)) |-> ##5 (out_prod == '0));

  // R6
  unit_prod_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_a == M'(1)) |-> ##5 (out_prod == $past(in_b, 5)));

  // R7
  hold_prod_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (filled && !s4_v) |=> $stable(out_prod));

  generate
    if (CW > FW) begin : g_pad_chk
      // R9
      pad_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s2_v |-> (comb_wide[CW-1:FW] == '0));
    end
  endgenerate

endmodule

// File: tb/gf_kmul_pipe_test.sv
module gf_kmul_pipe_test;

  localparam int           M  = 233;
  localparam logic [M-1:0] PL = (M'(1) << 74) | M'(1);
  localparam int           NV = 400;
  localparam int           LAT = 5;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [M-1:0] in_a = '0;
  logic [M-1:0] in_b = '0;
  logic         out_valid;
  logic [M-1:0] out_prod;

  gf_kmul_pipe #(.M(M), .POLY_LOW(PL), .LEAF(16)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_prod(out_prod)
  );

  always #5 clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [M-1:0] va [NV];
  logic [M-1:0] vb [NV];
  logic [M-1:0] ve [NV];
  logic         vv [NV];
  string        vt [NV];

  function automatic logic [M-1:0] rnd_elem();
    logic [255:0] t;
    t = '0;
    for (int i = 0; i < 8; i++) t = {t[223:0], $urandom()};
    return t[M-1:0];
  endfunction

  // Bit-serial shift-and-add with reduction (x^M == PL).
  function automatic logic [M-1:0] ref_mul(input logic [M-1:0] a, input logic [M-1:0] b);
    logic [M-1:0] r;
    logic         c;
    r = '0;
    for (int i = M - 1; i >= 0; i--) begin
      c = r[M-1];
      r = r << 1;
      if (c) r = r ^ PL;
      if (a[i]) r = r ^ b;
    end
    return r;
  endfunction

  task automatic chk_bit(input logic act, input logic exp, input string tag, input string what);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
    end
  endtask

  task automatic chk_vec(input logic [M-1:0] act, input logic [M-1:0] exp, input string tag, input string what);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  initial begin
    logic [M-1:0] ones, top, last_exp;
    bit           have_last;
    int           seed_ret;

    seed_ret = $urandom(32'd20240611);
    ones = '1;
    top  = M'(1) << (M - 1);

    for (int i = 0; i < NV; i++) begin
      va[i] = rnd_elem();
      vb[i] = rnd_elem();
      vv[i] = 1'b1;
      vt[i] = "R1";
      if (i % 13 == 7 && i > 10) begin
        vv[i] = 1'b0;
        vt[i] = "R3";
      end
    end
    va[0] = '0;         vt[0] = "R5";
    vb[1] = '0;         vt[1] = "R5";
    va[2] = M'(1);      vt[2] = "R6";
    vb[3] = M'(1);      vt[3] = "R6";
    va[4] = ones; vb[4] = ones; vt[4] = "R8";
    va[5] = top;  vb[5] = top;  vt[5] = "R9";
    va[6] = ones; vb[6] = top;  vt[6] = "R8";
    va[7] = top;                vt[7] = "R9";
    va[8] = '0;   vb[8] = '0;   vt[8] = "R5";
    for (int i = 0; i < NV; i++) ve[i] = ref_mul(va[i], vb[i]);

    // R8: x^(M-1) squared must land on x^(2M-2) reduced twice
    chk_vec(ve[5], ref_mul(top, top), "R8", "reference self-consistency");

    // R4: reset state
    repeat (3) @(negedge clk);
    chk_bit(out_valid, 1'b0, "R4", "valid during reset");
    rst_n = 1'b1;

    have_last = 1'b0;
    last_exp  = '0;
    for (int j = 0; j < NV + LAT + 1; j++) begin
      if (j >= LAT) begin
        int k;
        k = j - LAT;
        if (vv[k]) begin
          chk_bit(out_valid, 1'b1, "R2", $sformatf("valid for pair %0d", k));
          chk_vec(out_prod, ve[k], vt[k], $sformatf("product for pair %0d", k));
          last_exp  = ve[k];
          have_last = 1'b1;
        end else begin
          chk_bit(out_valid, 1'b0, "R3", $sformatf("bubble slot %0d", k));
          if (have_last) chk_vec(out_prod, last_exp, "R7", $sformatf("hold after bubble %0d", k));
        end
      end else begin
        chk_bit(out_valid, 1'b0, "R4", $sformatf("empty pipe cycle %0d", j));
      end
      if (j < NV) begin
        in_valid = vv[j];
        in_a     = va[j];
        in_b     = vb[j];
      end else begin
        in_valid = 1'b0;
        in_a     = rnd_elem();
        in_b     = rnd_elem();
      end
      @(negedge clk);
    end

    // R7: long idle tail keeps the last product
    chk_vec(out_prod, last_exp, "R7", "hold after idle tail");

    // R4: reset with a full pipeline
    for (int j = 0; j < 6; j++) begin
      in_valid = 1'b1;
      in_a     = rnd_elem();
      in_b     = rnd_elem();
      @(negedge clk);
    end
    chk_bit(out_valid, 1'b1, "R3", "full pipe before reset");
    rst_n = 1'b0;
    #1;
    chk_bit(out_valid, 1'b0, "R4", "valid cleared at reset assertion");
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int j = 0; j < LAT; j++) begin
      chk_bit(out_valid, 1'b0, "R4", $sformatf("no stale result cycle %0d", j));
      @(negedge clk);
    end

    // R2: single fresh pair timed from its capture edge
    in_valid = 1'b1;
    in_a     = top;
    in_b     = ones;
    @(negedge clk);
    in_valid = 1'b0;
    for (int j = 0; j < LAT - 2; j++) begin
      @(negedge clk);
      chk_bit(out_valid, 1'b0, "R2", $sformatf("early cycle %0d", j));
    end
    @(negedge clk);
    chk_bit(out_valid, 1'b1, "R2", "single pair due");
    chk_vec(out_prod, ref_mul(top, ones), "R9", "single pair product");
    @(negedge clk);
    chk_bit(out_valid, 1'b0, "R2", "single pair one cycle wide");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL R3 watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule